// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small fully-associative store that sits under a direct-mapped first-level cache, on the path between the cache and the next memory level. Every cache access probes it at the same time as the cache, with one tag comparator per entry. The buffer normally holds lines the cache has thrown out. When the cache misses and the buffer holds the wanted line, the two lines trade places. The buffer's copy goes to the cache one cycle later, and the line the cache gives up takes its slot. No request goes to the next level in that case.

When both the cache and the buffer miss, the block sends one request to the next level and keeps the line being displaced. That line is stored when the refill arrives. If the miss came from a parity error in the cache, the displaced line is untrusted. The buffer then stores the incoming refill line under the requested address instead. Entries are replaced in least-recently-used order, and the entry count may be as small as one.

Top module: `victim_store`

## Requirements
- R1: While `probeValid` is high, `probeHit` is high in the same cycle exactly when a valid entry's tag equals `probeAddr`, and `probeLine` then carries that entry's line. With no hit, `probeLine` is zero.
- R2: A probe with `cacheMiss` high that misses in the buffer raises `reqValid` for exactly the next cycle, with `reqAddr` equal to the probed address. The displaced line (`evictValid`, `evictAddr`, `evictLine` at the miss) is stored on the cycle `refillValid` is high, and it is visible to probes from the cycle after that.
- R3: A probe with `cacheMiss` high that hits in the buffer raises `fillValid` in the next cycle, with `fillAddr` equal to the probed address and `fillLine` equal to the buffer's copy. When `evictValid` is high and `parityErr` is low, the matched entry then holds `evictAddr`/`evictLine`.
- R4: An insertion overwrites the least recently used entry, or an empty one if any exists. Inserted entries and entries that receive a swapped line become most recently used. Probes with `cacheMiss` low do not change the order.
- R5: After a swap, the requested address no longer hits in the buffer, so no line is held in both places.
- R6: A double miss with `parityErr` high discards the displaced line. At refill, the buffer stores `refillLine` under the missed address.
- R7: A buffer hit with `parityErr` high discards the displaced line and frees the matched entry. The fill still delivers the buffer's copy.
- R8: A buffer hit with `evictValid` low frees the matched entry.
- R9: From a double miss until its refill, further misses cause no request, swap or fill. A `refillValid` pulse with no outstanding miss stores nothing.
- R10: After reset every entry is empty, and `probeHit`, `fillValid` and `reqValid` are low.
- R11: A probe with `cacheMiss` low leaves the buffer's contents unchanged.
- R12: A single-entry configuration performs insertion, replacement and swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probeValid | input | 1 | A cache access is being probed |
| probeAddr | input | ADDR_W | Line address of the access |
| cacheMiss | input | 1 | The direct-mapped cache missed on this access |
| parityErr | input | 1 | That miss was caused by a parity error |
| evictValid | input | 1 | The cache slot being displaced holds a line |
| evictAddr | input | ADDR_W | Line address of the displaced line |
| evictLine | input | LINE_W | Data of the displaced line |
| probeHit | output | 1 | The probe matched a buffer entry |
| probeLine | output | LINE_W | Data of the matched entry |
| fillValid | output | 1 | Cache reload from the buffer this cycle |
| fillAddr | output | ADDR_W | Address of the reloaded line |
| fillLine | output | LINE_W | Data of the reloaded line |
| reqValid | output | 1 | Request to the next level |
| reqAddr | output | ADDR_W | Line address requested |
| refillValid | input | 1 | Next level returns the requested line |
| refillLine | input | LINE_W | Returned line data |

## Verification
`probeHit` and `probeLine` are combinational, so they are due in the cycle of the probe. `fillValid` and `reqValid` appear one clock after the triggering miss. A refill's insertion becomes visible to a probe one clock after `refillValid`. The bench drives every input just after a falling edge and samples 1 ns later. Its reference model advances one step per rising edge, so every output is compared in the exact cycle the model predicts it. Directed probes with `cacheMiss` low check the buffer's contents without disturbing the replacement order.

// File: rtl/vc_pkg.sv
package vc_pkg;
  // strobes from control to datapath, at most one action per class per cycle
  typedef struct packed {
    logic swapKeep;   // hit: replace matched entry with the displaced line, make MRU
    logic swapFree;   // hit: empty the matched entry, move it to LRU end
    logic capture;    // double miss: latch displaced line and miss address
    logic insVictim;  // refill: store the latched displaced line
    logic insRefill;  // refill after parity miss: store the refill line
  } vcCtl_t;
endpackage

// File: rtl/vc_lru.sv
module vc_lru #(
  parameter int NUM_ENTRIES = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touchEn,
  input  logic          retireEn,
  input  logic [IW-1:0] idxIn,
  output logic [IW-1:0] lruIdx
);
  // ord[0] is the most recently used entry index, ord[N-1] the least
  logic [NUM_ENTRIES-1:0][IW-1:0] ord, nxt;
  logic [IW-1:0] pos;

  always_comb begin
    pos = '0;
    for (int k = 0; k < NUM_ENTRIES; k++)
      if (ord[k] == idxIn) pos = IW'(k);
  end

  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_pos
    logic [IW-1:0] fromPrev, fromNext;
    if (k == 0) begin : g_head
      assign fromPrev = idxIn;
    end else begin : g_mid
      assign fromPrev = ord[k-1];
    end
    if (k == NUM_ENTRIES - 1) begin : g_tail
      assign fromNext = idxIn;
    end else begin : g_body
      assign fromNext = ord[k+1];
    end
    always_comb begin
      nxt[k] = ord[k];
      if (touchEn && (IW'(k) <= pos))       nxt[k] = fromPrev;
      else if (retireEn && (IW'(k) >= pos)) nxt[k] = fromNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_ENTRIES; k++) ord[k] <= IW'(k);
    end else begin
      ord <= nxt;
    end
  end

  assign lruIdx = ord[NUM_ENTRIES-1];

  logic [(1<<IW)-1:0] seen;
  always_comb begin
    seen = '0;
    for (int k = 0; k < NUM_ENTRIES; k++) seen[ord[k]] = 1'b1;
  end

  // R4
  order_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == NUM_ENTRIES);
endmodule

// File: rtl/vc_datapath.sv
module vc_datapath
  import vc_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W = 28,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  vcCtl_t            ctl,
  input  logic [ADDR_W-1:0] probeAddr,
  input  logic [ADDR_W-1:0] evictAddr,
  input  logic [LINE_W-1:0] evictLine,
  input  logic [LINE_W-1:0] refillLine,
  output logic              anyHit,
  output logic [LINE_W-1:0] hitLine,
  output logic              fillValid,
  output logic [ADDR_W-1:0] fillAddr,
  output logic [LINE_W-1:0] fillLine,
  output logic [ADDR_W-1:0] missAddr
);
  localparam int IW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [NUM_ENTRIES-1:0]             valid;
  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] tags;
  logic [NUM_ENTRIES-1:0][LINE_W-1:0] lines;
  logic [NUM_ENTRIES-1:0]             hitVec;
  logic [IW-1:0]                      hitIdx, lruIdx, lruSel;
  logic [ADDR_W-1:0]                  pendAddr;
  logic [LINE_W-1:0]                  pendLine;
  logic                               insert;
  logic [ADDR_W-1:0]                  insAddr;
  logic [LINE_W-1:0]                  insLine;

  // one comparator per entry
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
    assign hitVec[e] = valid[e] && (tags[e] == probeAddr);
  end

  always_comb begin
    hitIdx = '0;
    for (int e = 0; e < NUM_ENTRIES; e++)
      if (hitVec[e]) hitIdx = IW'(e);
  end

  assign anyHit  = |hitVec;
  assign hitLine = anyHit ? lines[hitIdx] : '0;

  assign insert  = ctl.insVictim | ctl.insRefill;
  assign insAddr = ctl.insRefill ? missAddr : pendAddr;
  assign insLine = ctl.insRefill ? refillLine : pendLine;
  assign lruSel  = insert ? lruIdx : hitIdx;

  vc_lru #(.NUM_ENTRIES(NUM_ENTRIES), .IW(IW)) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .touchEn  (ctl.swapKeep | insert),
    .retireEn (ctl.swapFree),
    .idxIn    (lruSel),
    .lruIdx   (lruIdx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid     <= '0;
      tags      <= '0;
      lines     <= '0;
      fillValid <= 1'b0;
      fillAddr  <= '0;
      fillLine  <= '0;
      pendAddr  <= '0;
      pendLine  <= '0;
      missAddr  <= '0;
    end else begin
      fillValid <= ctl.swapKeep | ctl.swapFree;
      if (ctl.swapKeep | ctl.swapFree) begin
        fillAddr <= probeAddr;
        fillLine <= lines[hitIdx];
      end
      if (ctl.swapKeep) begin
        tags[hitIdx]  <= evictAddr;
        lines[hitIdx] <= evictLine;
      end
      if (ctl.swapFree) valid[hitIdx] <= 1'b0;
      if (ctl.capture) begin
        pendAddr <= evictAddr;
        pendLine <= evictLine;
        missAddr <= probeAddr;
      end
      if (insert) begin
        valid[lruIdx] <= 1'b1;
        tags[lruIdx]  <= insAddr;
        lines[lruIdx] <= insLine;
      end
    end
  end

  // R5
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitVec));

  // R3
  fill_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.swapKeep | ctl.swapFree) |=> fillValid);

  // R6
  refill_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.insRefill |=> (lines[$past(lruIdx)] == $past(refillLine)) && valid[$past(lruIdx)]);
endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
  import vc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   probeValid,
  input  logic   cacheMiss,
  input  logic   parityErr,
  input  logic   evictValid,
  input  logic   anyHit,
  input  logic   refillValid,
  output vcCtl_t ctl,
  output logic   reqValid
);
  typedef enum logic {ST_IDLE, ST_WAIT} vcState_t;
  vcState_t state;
  logic pendPar, pendKeep, miss, refillNow;

  assign miss      = probeValid && cacheMiss && (state == ST_IDLE);
  assign refillNow = (state == ST_WAIT) && refillValid;

  always_comb begin
    ctl           = '0;
    ctl.swapKeep  = miss && anyHit && evictValid && !parityErr;
    ctl.swapFree  = miss && anyHit && !(evictValid && !parityErr);
    ctl.capture   = miss && !anyHit;
    ctl.insRefill = refillNow && pendPar;
    ctl.insVictim = refillNow && !pendPar && pendKeep;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pendPar  <= 1'b0;
      pendKeep <= 1'b0;
      reqValid <= 1'b0;
    end else begin
      reqValid <= ctl.capture;
      if (ctl.capture) begin
        state    <= ST_WAIT;
        pendPar  <= parityErr;
        pendKeep <= evictValid && !parityErr;
      end else if (refillNow) begin
        state <= ST_IDLE;
      end
    end
  end

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.capture |=> reqValid ##1 !reqValid);

  // R9
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !(ctl.swapKeep || ctl.swapFree || ctl.capture));
endmodule

// File: rtl/victim_store.sv
module victim_store
  import vc_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W = 28,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              probeValid,
  input  logic [ADDR_W-1:0] probeAddr,
  input  logic              cacheMiss,
  input  logic              parityErr,
  input  logic              evictValid,
  input  logic [ADDR_W-1:0] evictAddr,
  input  logic [LINE_W-1:0] evictLine,
  output logic              probeHit,
  output logic [LINE_W-1:0] probeLine,
  output logic              fillValid,
  output logic [ADDR_W-1:0] fillAddr,
  output logic [LINE_W-1:0] fillLine,
  output logic              reqValid,
  output logic [ADDR_W-1:0] reqAddr,
  input  logic              refillValid,
  input  logic [LINE_W-1:0] refillLine
);
  vcCtl_t            ctl;
  logic              anyHit;
  logic [LINE_W-1:0] hitLine;

  vc_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .probeValid  (probeValid),
    .cacheMiss   (cacheMiss),
    .parityErr   (parityErr),
    .evictValid  (evictValid),
    .anyHit      (anyHit),
    .refillValid (refillValid),
    .ctl         (ctl),
    .reqValid    (reqValid)
  );

  vc_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .probeAddr  (probeAddr),
    .evictAddr  (evictAddr),
    .evictLine  (evictLine),
    .refillLine (refillLine),
    .anyHit     (anyHit),
    .hitLine    (hitLine),
    .fillValid  (fillValid),
    .fillAddr   (fillAddr),
    .fillLine   (fillLine),
    .missAddr   (reqAddr)
  );

  assign probeHit  = probeValid && anyHit;
  assign probeLine = probeHit ? hitLine : '0;
endmodule

// File: tb/test_victim_store.sv
module test_victim_store;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 28;
  localparam int LW = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pv = 0, cm = 0, par = 0, ev = 0, rv = 0;
  logic [AW-1:0] pa = '0, ea = '0;
  logic [LW-1:0] ed = '0, rd = '0;
  logic hit, fV, rqV;
  logic [LW-1:0] hLine, fLine;
  logic [AW-1:0] fA, rqA;

  // single-entry instance, own stimulus
  logic spv = 0, scm = 0, sev = 0, srv = 0;
  logic [AW-1:0] spa = '0, sea = '0;
  logic [LW-1:0] sed = '0, srd = '0;
  logic sHit, sFV, sRqV;
  logic [LW-1:0] sHLine, sFLine;
  logic [AW-1:0] sFA, sRqA;

  always #(CLK_PERIOD/2) clk = ~clk;

  victim_store #(.NUM_ENTRIES(N), .ADDR_W(AW), .LINE_W(LW)) i_victim_store (
    .clk(clk), .rst_n(rst_n), .probeValid(pv), .probeAddr(pa), .cacheMiss(cm),
    .parityErr(par), .evictValid(ev), .evictAddr(ea), .evictLine(ed),
    .probeHit(hit), .probeLine(hLine), .fillValid(fV), .fillAddr(fA), .fillLine(fLine),
    .reqValid(rqV), .reqAddr(rqA), .refillValid(rv), .refillLine(rd));

  victim_store #(.NUM_ENTRIES(1), .ADDR_W(AW), .LINE_W(LW)) i_small (
    .clk(clk), .rst_n(rst_n), .probeValid(spv), .probeAddr(spa), .cacheMiss(scm),
    .parityErr(1'b0), .evictValid(sev), .evictAddr(sea), .evictLine(sed),
    .probeHit(sHit), .probeLine(sHLine), .fillValid(sFV), .fillAddr(sFA), .fillLine(sFLine),
    .reqValid(sRqV), .reqAddr(sRqA), .refillValid(srv), .refillLine(srd));

  typedef struct { logic [AW-1:0] a; logic [LW-1:0] d; } ent_t;
  ent_t q[$];
  bit waiting = 0, pendKeep = 0, pendPar = 0;
  logic [AW-1:0] pendA = '0, missA = '0, expFillA = '0, expReqA = '0;
  logic [LW-1:0] pendD = '0, expFillD = '0;
  bit expFill = 0, expReq = 0;
  bit lastHit, lastFill, lastReq;
  int vectors = 0, misses = 0;
  bit done = 0;

  function automatic logic [LW-1:0] mk(input logic [AW-1:0] a);
    return {4'h5, a, 4'hA, ~a};
  endfunction

  task automatic check(input string r, input string what, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", r, what, act, exp, $time);
    end
  endtask

  task automatic modelInsert(input logic [AW-1:0] a, input logic [LW-1:0] d);
    q.push_front('{a, d});
    if (q.size() > N) void'(q.pop_back());
  endtask

  task automatic step(input bit ipv, input logic [AW-1:0] ipa, input bit icm, input bit ipar,
                      input bit iev, input logic [AW-1:0] iea, input bit irv, input logic [LW-1:0] ird);
    int hi;
    bit miss, nFill, nReq;
    @(negedge clk);
    pv = ipv; pa = ipa; cm = icm; par = ipar; ev = iev; ea = iea; ed = mk(iea); rv = irv; rd = ird;
    #1;
    hi = -1;
    foreach (q[i]) if (q[i].a == ipa) hi = i;
    lastHit = hit; lastFill = fV; lastReq = rqV;
    check("R1", "probeHit", LW'(hit), LW'(ipv && hi >= 0));
    check("R1", "probeLine", hLine, (ipv && hi >= 0) ? q[hi].d : '0);
    check("R3", "fillValid", LW'(fV), LW'(expFill));
    if (expFill) begin
      check("R3", "fillAddr", LW'(fA), LW'(expFillA));
      check("R3", "fillLine", fLine, expFillD);
    end
    check("R2", "reqValid", LW'(rqV), LW'(expReq));
    if (expReq) check("R2", "reqAddr", LW'(rqA), LW'(expReqA));
    miss = ipv && icm && !waiting;
    nFill = 0; nReq = 0;
    if (miss && hi >= 0) begin
      nFill = 1; expFillA = ipa; expFillD = q[hi].d;
      q.delete(hi);
      if (iev && !ipar) q.push_front('{iea, mk(iea)});
    end else if (miss) begin
      nReq = 1; expReqA = ipa; missA = ipa; pendA = iea; pendD = mk(iea);
      pendKeep = iev && !ipar; pendPar = ipar;
    end
    if (waiting && irv) begin
      if (pendPar) modelInsert(missA, ird);
      else if (pendKeep) modelInsert(pendA, pendD);
      waiting = 0;
    end
    if (miss && hi < 0) waiting = 1;
    expFill = nFill; expReq = nReq;
  endtask

  task automatic idle(); step(0, '0, 0, 0, 0, '0, 0, '0); endtask
  task automatic doMiss(input logic [AW-1:0] a, input bit iev, input logic [AW-1:0] v, input bit ipar);
    step(1, a, 1, ipar, iev, v, 0, '0);
  endtask
  task automatic doRefill(input logic [LW-1:0] d); step(0, '0, 0, 0, 0, '0, 1, d); endtask
  task automatic expectHit(input logic [AW-1:0] a, input bit exp, input string r);
    step(1, a, 0, 0, 0, '0, 0, '0);
    check(r, "directed probe hit", LW'(lastHit), LW'(exp));
  endtask
  task automatic fullMiss(input logic [AW-1:0] a, input logic [AW-1:0] v);
    doMiss(a, 1, v, 0); idle(); doRefill(mk(a));
  endtask

  task automatic sStep(input bit ipv, input logic [AW-1:0] ipa, input bit icm,
                       input bit iev, input logic [AW-1:0] iea, input bit irv);
    @(negedge clk);
    spv = ipv; spa = ipa; scm = icm; sev = iev; sea = iea; sed = mk(iea); srv = irv; srd = mk(ipa);
    #1;
    lastHit = sHit; lastFill = sFV; lastReq = sRqV;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R10: empty after reset
    idle();
    check("R10", "fillValid after reset", LW'(lastFill), '0);
    check("R10", "reqValid after reset", LW'(lastReq), '0);
    expectHit(28'h100, 0, "R10");
    // R2: double miss, request next cycle, victim stored at refill
    doMiss(28'h100, 1, 28'h200, 0);
    idle();
    check("R2", "request pulse", LW'(lastReq), 1);
    idle(); doRefill(mk(28'h100));
    expectHit(28'h200, 1, "R2");
    // R4: fifth insertion pushes out the oldest
    fullMiss(28'h101, 28'h201); fullMiss(28'h102, 28'h202);
    fullMiss(28'h103, 28'h203); fullMiss(28'h104, 28'h204);
    expectHit(28'h200, 0, "R4");
    expectHit(28'h201, 1, "R4");
    // R3 / R5: swap on buffer hit
    doMiss(28'h202, 1, 28'h400, 0);
    idle();
    check("R3", "fill after swap", LW'(lastFill), 1);
    expectHit(28'h202, 0, "R5");
    expectHit(28'h400, 1, "R3");
    fullMiss(28'h500, 28'h205);
    expectHit(28'h201, 0, "R4");
    expectHit(28'h400, 1, "R4");
    // R6: parity miss stores the refill line
    doMiss(28'h600, 1, 28'h700, 1); idle(); doRefill(mk(28'h600));
    expectHit(28'h700, 0, "R6");
    expectHit(28'h600, 1, "R6");
    // R7: parity hit frees the entry
    doMiss(28'h600, 1, 28'h701, 1); idle();
    check("R7", "fill on parity hit", LW'(lastFill), 1);
    expectHit(28'h600, 0, "R7");
    expectHit(28'h701, 0, "R7");
    // R8: hit with no displaced line frees the entry
    doMiss(28'h400, 0, 28'h0, 0); idle();
    expectHit(28'h400, 0, "R8");
    // R9: misses while waiting, and a stray refill, are ignored
    doMiss(28'h800, 1, 28'h900, 0);
    doMiss(28'h204, 1, 28'h901, 0);
    idle();
    check("R9", "no fill while waiting", LW'(lastFill), 0);
    check("R9", "no second request", LW'(lastReq), 0);
    expectHit(28'h204, 1, "R9");
    doRefill(mk(28'h800));
    expectHit(28'h900, 1, "R9");
    doRefill(mk(28'h801));
    expectHit(28'h800, 0, "R9");
    // R11: cache-hit probe leaves contents alone
    step(1, 28'h204, 0, 0, 1, 28'hA00, 0, '0);
    expectHit(28'hA00, 0, "R11");
    expectHit(28'h204, 1, "R11");
    idle();
    // R12: single-entry configuration
    sStep(1, 28'h10, 1, 1, 28'h20, 0);
    sStep(0, '0, 0, 0, '0, 0);
    check("R12", "small request", LW'(lastReq), 1);
    sStep(0, '0, 0, 0, '0, 1);
    sStep(1, 28'h20, 0, 0, '0, 0);
    check("R12", "small hit", LW'(lastHit), 1);
    check("R12", "small line", sHLine, mk(28'h20));
    sStep(1, 28'h11, 1, 1, 28'h21, 0);
    sStep(0, '0, 0, 0, '0, 1);
    sStep(1, 28'h20, 0, 0, '0, 0);
    check("R12", "small replaced", LW'(lastHit), 0);
    sStep(1, 28'h21, 1, 1, 28'h30, 0);
    check("R12", "small swap hit", LW'(lastHit), 1);
    sStep(1, 28'h30, 0, 0, '0, 0);
    check("R12", "small fill", LW'(lastFill), 1);
    check("R12", "small fill line", sFLine, mk(28'h21));
    check("R12", "small holds victim", LW'(lastHit), 1);
    sStep(0, '0, 0, 0, '0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule